// File: doc/BRIEF.md
# Multi-Output Level Interrupt Controller

This block collects nine external interrupt request lines and presents them on three parent interrupt outputs. Each raw line is first passed through a two-flop synchroniser. It is then normalised to active high by a per-source polarity bit. A rising edge of the normalised level marks the source pending. Software reaches the block through a small 32-bit register bus that has a write strobe, a byte address and a combinational read-data path.

There are four word registers. The polarity register sets which level of each source counts as active. Sources 1 and 8 are fixed active high and source 2 is fixed active low, whatever is written. Each parent output has its own control/status word. The low half of that word holds per-source enables. The upper half holds per-source pending flags, which software clears by writing ones. A source can be enabled on any number of the three outputs. Every output keeps its own pending copy, so acknowledging a source on one output leaves the other outputs untouched. An output is high while any source is both pending and enabled in its word.

Top module: `lvl_irq_hub`

## Requirements
- R1: After reset the word at byte address 0x0 reads 0x00000102, the words at 0x4, 0x8 and 0xC read 0, and all three outputs are low.
- R2: A write to address 0x0 sets polarity bit k (bit k, 1 = active high, 0 = active low) for sources 0 and 3 to 7. Bits 31:9 of that word read as 0.
- R3: Source 1 and source 8 are always treated as active high and source 2 as active low. Their polarity bits read 1, 1 and 0 whatever is written to them.
- R4: When a source's active level begins, its pending flag becomes set on the third rising clock edge after the input changes, in the word of every output.
- R5: A pending flag is recorded whether or not the source is enabled on that output.
- R6: In the word of output n (address 0x4 + 4n), writing 1 to bit 16+k clears pending flag k, and writing 0 there leaves it unchanged. If source k is still at its active level when the write lands, the flag stays set.
- R7: Output n is high in the cycle after any register update that leaves some source both pending and enabled in word n. It is low otherwise.
- R8: Bits 8:0 of word n are enables that read back as written. Bits 15:9 and 31:25 read as 0 and ignore writes. A write to one word changes no enable in another word.
- R9: The word is selected by address bits 3:2: 0 selects the polarity word, and 1, 2 and 3 select outputs 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Byte address of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_in | input | 9 | Raw interrupt request lines |
| irq_out | output | 3 | Parent interrupt outputs, active high |

## Verification
The hardest case to reach is an acknowledge that lands while the source is still at its active level. The flag must survive the write, and it must clear only on a later acknowledge after the level has gone away. The stimulus holds source 1 active across the first acknowledge and then releases it. It then issues a zero-data write and a real acknowledge, which separates the keep, no-effect and clear outcomes. A polarity rewrite with the inputs held still creates edges purely from the configuration change. This shows that pending capture happens whether or not a source is enabled, before any enables are set.

// File: rtl/lvl_irq_hub.sv
module lvl_irq_hub #(
  parameter int NSRC = 9,
  parameter int NOUT = 3,
  parameter int AW = 4,
  parameter logic [NSRC-1:0] FIX_MASK = 9'h106,
  parameter logic [NSRC-1:0] FIX_POL = 9'h102
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [NSRC-1:0] src_in,
  output logic [NOUT-1:0] irq_out
);
  localparam int PEND_LSB = 16;
  localparam int IW = AW - 2;

  logic [IW-1:0]   idx;
  logic [NSRC-1:0] cfg_q, pol, sync1, sync2, lvl, lvl_q, rise;
  logic [NSRC-1:0] en_q [NOUT];
  logic [NSRC-1:0] pend_q [NOUT];
  logic [NSRC-1:0] ack [NOUT];
  logic [NOUT-1:0] wsel;

  assign idx  = bus_addr[AW-1:2];
  assign pol  = (cfg_q & ~FIX_MASK) | (FIX_POL & FIX_MASK);
  assign lvl  = ~(sync2 ^ pol);
  assign rise = lvl & ~lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      lvl_q <= '1;
      cfg_q <= '0;
    end else begin
      sync1 <= src_in;
      sync2 <= sync1;
      lvl_q <= lvl;
      if (bus_wr && idx == '0) cfg_q <= bus_wdata[NSRC-1:0];
    end
  end

  always_comb begin
    for (int n = 0; n < NOUT; n++) begin
      wsel[n] = bus_wr && (idx == IW'(n + 1));
      ack[n]  = wsel[n] ? bus_wdata[PEND_LSB +: NSRC] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < NOUT; n++) begin
        en_q[n]   <= '0;
        pend_q[n] <= '0;
      end
    end else begin
      for (int n = 0; n < NOUT; n++) begin
        if (wsel[n]) en_q[n] <= bus_wdata[NSRC-1:0];
        pend_q[n] <= (pend_q[n] & ~ack[n]) | rise | (ack[n] & lvl);
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (idx == '0) bus_rdata[NSRC-1:0] = pol;
    for (int n = 0; n < NOUT; n++) begin
      if (idx == IW'(n + 1)) begin
        bus_rdata[NSRC-1:0] = en_q[n];
        bus_rdata[PEND_LSB +: NSRC] = pend_q[n];
      end
    end
  end

  always_comb begin
    for (int n = 0; n < NOUT; n++) irq_out[n] = |(pend_q[n] & en_q[n]);
  end

  for (genvar n = 0; n < NOUT; n++) begin : g_chk
    assert_en_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !wsel[n] |=> $stable(en_q[n]));
    for (genvar k = 0; k < NSRC; k++) begin : g_src
      assert_pend_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q[n][k] && !wsel[n]) |=> pend_q[n][k]);
      assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wsel[n] && bus_wdata[PEND_LSB + k] && !lvl[k] && !rise[k]) |=> !pend_q[n][k]);
      assert_pend_from_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q[n][k]) |-> $past(lvl[k]));
    end
  end
endmodule

// File: tb/sim_lvl_irq_hub.sv
`timescale 1ns/1ps
module sim_lvl_irq_hub;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [8:0]  src_in = 9'h0FD;
  logic [2:0]  irq_out;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lvl_irq_hub u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in), .irq_out(irq_out));

  // behavioural reference: delay line of inputs, level memory, per-output flags
  logic [8:0] m_cfg, m_lq, m_en [3], m_pend [3];
  logic [8:0] m_hist [$];

  function automatic logic [8:0] m_pol();
    return (m_cfg & ~9'h106) | 9'h102;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cfg = 0; m_lq = '1; m_hist = {9'h0, 9'h0};
      for (int n = 0; n < 3; n++) begin m_en[n] = 0; m_pend[n] = 0; end
    end else begin
      logic [8:0] lv, ak;
      lv = ~(m_hist[0] ^ m_pol());
      for (int n = 0; n < 3; n++) begin
        ak = (bus_wr && bus_addr[3:2] == 2'(n + 1)) ? bus_wdata[24:16] : 9'h0;
        m_pend[n] = (m_pend[n] & ~ak) | (lv & ~m_lq) | (ak & lv);
        if (bus_wr && bus_addr[3:2] == 2'(n + 1)) m_en[n] = bus_wdata[8:0];
      end
      if (bus_wr && bus_addr[3:2] == 0) m_cfg = bus_wdata[8:0];
      m_lq = lv;
      void'(m_hist.pop_front());
      m_hist.push_back(src_in);
    end
  end

  always @(negedge clk) if (!done) begin
    logic [2:0] e;
    e = '0;
    if (rst_n) for (int n = 0; n < 3; n++) e[n] = |(m_pend[n] & m_en[n]);
    checks++;
    if (irq_out !== e) begin
      fails++;
      $display("FAIL R7 model irq_out actual=%b expected=%b t=%0t", irq_out, e, $time);
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); bus_addr = a; #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic idle(input int c);
    repeat (c) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(4);
    // R1 reset state
    rd(4'h0, 32'h0000_0102, "R1 cfg reset");
    rd(4'h4, 0, "R1 out0 reset");
    rd(4'h8, 0, "R1 out1 reset");
    rd(4'hC, 0, "R1 out2 reset");
    chk("R1 irq reset", {29'b0, irq_out}, 0);
    // R2 R3 polarity write, fixed bits forced; R5 edges captured with enables off
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, 32'h0000_01FB, "R2 cfg all ones");
    idle(4);
    rd(4'h4, 32'h00F9_0000, "R5 pend without enable");
    rd(4'hC, 32'h00F9_0000, "R4 pend in every output");
    wr(4'h0, 32'h0);
    rd(4'h0, 32'h0000_0102, "R3 cfg fixed bits");
    idle(4);
    wr(4'h4, 32'h01FF_0000);
    wr(4'h8, 32'h01FF_0000);
    wr(4'hC, 32'h01FF_0000);
    rd(4'hC, 0, "R6 w1c clears all");
    // R8 R9 enables and unused bits
    wr(4'h4, 32'h0000_01FF);
    wr(4'h8, 32'hFE00_FE01);
    rd(4'h8, 32'h0000_0001, "R8 unused bits zero");
    rd(4'h4, 32'h0000_01FF, "R9 out0 word");
    rd(4'hC, 0, "R8 other word untouched");
    // R4 timing: source 1 active high
    @(negedge clk); src_in = 9'h0FF;
    @(negedge clk); chk("R4 edge1", {29'b0, irq_out}, 0);
    @(negedge clk); chk("R4 edge2", {29'b0, irq_out}, 0);
    @(negedge clk); chk("R4 edge3", {29'b0, irq_out}, 3'b001);
    rd(4'hC, 32'h0002_0000, "R5 pend out2 disabled");
    // R6 ack while level held
    wr(4'h4, 32'h0002_01FF);
    rd(4'h4, 32'h0002_01FF, "R6 ack while active");
    @(negedge clk); src_in = 9'h0FD;
    idle(4);
    wr(4'h4, 32'h0000_01FF);
    rd(4'h4, 32'h0002_01FF, "R6 write zero no effect");
    wr(4'h4, 32'h0002_01FF);
    rd(4'h4, 32'h0000_01FF, "R6 ack clears");
    chk("R6 irq low after ack", {29'b0, irq_out}, 0);
    // R7 output combination
    @(negedge clk); src_in = 9'h0FC;
    idle(3);
    chk("R7 src0 on out0 out1", {29'b0, irq_out}, 3'b011);
    wr(4'hC, 32'h0000_0002);
    chk("R7 enable existing pend", {29'b0, irq_out}, 3'b111);
    wr(4'hC, 32'h0002_0002);
    chk("R7 ack drops out2", {29'b0, irq_out}, 3'b011);
    // R3 source 2 stays active low
    wr(4'h0, 32'h0000_0004);
    rd(4'h0, 32'h0000_0102, "R3 bit2 forced low");
    @(negedge clk); src_in = 9'h0F8;
    idle(4);
    rd(4'h8, 32'h0007_0001, "R3 src2 active low");
    idle(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule